// File: doc/BRIEF.md
# Over-Temperature Alarm with Fault Queue

This block watches a stream of 9-bit two's complement temperature samples, each worth half a degree, and drives one alarm line. Every valid sample is compared with a programmable trip threshold and a lower hysteresis threshold. The alarm changes state only after a programmable number of consecutive qualifying samples, so a single noisy reading does not trip it.

Two behaviours are available. In comparator mode the alarm works like a thermostat: it turns on when the temperature rises past the trip threshold and turns off when it falls under the hysteresis threshold. In latched mode each qualifying event sets a sticky alarm that stays on until the register interface reports a read of any register. The next event after that clear is the opposite crossing, so hot and cold events alternate. A sleep input freezes sampling. A polarity input picks whether the active alarm appears as a low or a high level on the output. The thresholds and the configuration come from a register block outside this one. That block holds the power-up values of 0x0A0 for trip and 0x096 for hysteresis.

Top module: `ota_alarm`

## Requirements
- R1: The depth code selects how many consecutive qualifying samples cause a transition: code 2'b00 needs 1, 2'b01 needs 2, 2'b10 needs 4 and 2'b11 needs 6.
- R2: Only cycles with smp_valid high count as samples. A valid sample that does not qualify returns the fault count to zero, so the qualifying samples must be consecutive.
- R3: In comparator mode (cfg_latched = 0) an inactive alarm becomes active when samples are strictly greater than trip_lvl. An active alarm becomes inactive when samples are strictly less than hyst_lvl. A sample equal to a threshold never qualifies.
- R4: In latched mode (cfg_latched = 1) the first qualifying event is a sample above trip_lvl. It sets the alarm, and the alarm then holds whatever the samples do. After each clear the armed event swaps between "above trip_lvl" and "below hyst_lvl".
- R5: A one-cycle rd_pulse clears a set alarm in latched mode. In comparator mode rd_pulse has no effect.
- R6: While cfg_sleep is high, samples are ignored and the fault count is held at zero. Sleep clears a latched alarm, but the armed direction is kept. Sleep leaves the comparator-mode alarm unchanged.
- R7: With cfg_act_high = 0 the output is low while the alarm is active and high otherwise. With cfg_act_high = 1 the output is inverted.
- R8: A change of cfg_latched returns the fault count to zero.
- R9: After reset the alarm is inactive in both modes and latched mode is armed for the above-trip event.
- R10: All comparisons are signed two's complement on 9 bits.
- R11: Each transition shows on alarm_out right after the clock edge that samples the deciding input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | A new conversion result is present this cycle |
| smp_temp | input | 9 | Signed temperature sample, 0.5 degree per LSB |
| trip_lvl | input | 9 | Signed trip threshold |
| hyst_lvl | input | 9 | Signed hysteresis threshold |
| cfg_sleep | input | 1 | Sleep: ignore samples, clear latched alarm |
| cfg_latched | input | 1 | 0 = comparator mode, 1 = latched mode |
| cfg_act_high | input | 1 | 0 = active-low output, 1 = active-high output |
| cfg_depth | input | 2 | Fault-queue depth code |
| rd_pulse | input | 1 | One-cycle pulse marking a read of any register |
| alarm_out | output | 1 | Alarm level after polarity |

## Verification
Most internal faults show up one sample late, or one read late, on alarm_out. A fault count that is not reset by a good sample, by sleep or by a mode change makes the alarm trip one sample early. A wrong armed direction in latched mode makes the alarm ignore a cold crossing, or respond to a hot crossing it should ignore, right after a read. The alarm state is visible in the cycle after the deciding edge. So each step of the bench compares the output immediately, and a wrong state is caught at the first sample that should have changed it or left it alone.

// File: rtl/ota_pkg.sv
package ota_pkg;

  localparam int TEMP_W = 9;
  localparam int CNT_W  = 3;

  typedef logic signed [TEMP_W-1:0] temp_t;

  // number of consecutive qualifying samples for a depth code
  function automatic logic [CNT_W-1:0] depth_need(input logic [1:0] code);
    case (code)
      2'b00:   depth_need = CNT_W'(1);
      2'b01:   depth_need = CNT_W'(2);
      2'b10:   depth_need = CNT_W'(4);
      default: depth_need = CNT_W'(6);
    endcase
  endfunction

endpackage

// File: rtl/ota_thresh_cmp.sv
module ota_thresh_cmp #(
  parameter int W = 9
) (
  input  logic [W-1:0] temp_i,
  input  logic [W-1:0] trip_i,
  input  logic [W-1:0] hyst_i,
  output logic         above_trip_o,
  output logic         below_hyst_o
);

  // strict signed comparisons; equality never qualifies
  always_comb begin
    above_trip_o = $signed(temp_i) > $signed(trip_i);
    below_hyst_o = $signed(temp_i) < $signed(hyst_i);
  end

endmodule

// File: rtl/ota_fault_queue.sv
module ota_fault_queue
  import ota_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       smp_en_i,
  input  logic       match_i,
  input  logic       clr_i,
  input  logic [1:0] depth_i,
  output logic       fire_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc, need;

  always_comb begin
    need    = depth_need(depth_i);
    cnt_inc = cnt_q + CNT_W'(1);
    cnt_d   = cnt_q;
    fire_o  = 1'b0;
    if (clr_i) begin
      cnt_d = '0;
    end else if (smp_en_i) begin
      if (match_i) begin
        if (cnt_inc >= need) begin
          fire_o = 1'b1;
          cnt_d  = '0;
        end else begin
          cnt_d = cnt_inc;
        end
      end else begin
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(6));

  assert_clr_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));

  assert_bad_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en_i && !match_i) |=> (cnt_q == '0));

endmodule

// File: rtl/ota_event_state.sv
module ota_event_state (
  input  logic clk,
  input  logic rst_n,
  input  logic latched_mode_i,
  input  logic sleep_i,
  input  logic rd_i,
  input  logic above_trip_i,
  input  logic below_hyst_i,
  input  logic fire_i,
  output logic match_o,
  output logic hold_o,
  output logic alarm_o
);

  logic cmp_act_q, cmp_act_d;
  logic lat_q, lat_d;
  logic arm_cold_q, arm_cold_d;

  // qualifying condition for the event currently armed
  always_comb begin
    if (latched_mode_i) match_o = arm_cold_q ? below_hyst_i : above_trip_i;
    else                match_o = cmp_act_q  ? below_hyst_i : above_trip_i;
    hold_o  = latched_mode_i && lat_q;
    alarm_o = latched_mode_i ? lat_q : cmp_act_q;
  end

  always_comb begin
    cmp_act_d  = cmp_act_q;
    lat_d      = lat_q;
    arm_cold_d = arm_cold_q;
    if (!latched_mode_i) begin
      if (fire_i) cmp_act_d = !cmp_act_q;
    end
    if (sleep_i) begin
      lat_d = 1'b0;
    end else if (latched_mode_i && fire_i) begin
      lat_d      = 1'b1;
      arm_cold_d = !arm_cold_q;
    end else if (latched_mode_i && rd_i) begin
      lat_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_act_q  <= 1'b0;
      lat_q      <= 1'b0;
      arm_cold_q <= 1'b0;
    end else begin
      cmp_act_q  <= cmp_act_d;
      lat_q      <= lat_d;
      arm_cold_q <= arm_cold_d;
    end
  end

  assert_cmp_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(fire_i && !latched_mode_i) |=> $stable(cmp_act_q));

  assert_latch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q && latched_mode_i && !rd_i && !sleep_i) |=> lat_q);

  assert_rd_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && latched_mode_i && !fire_i && !sleep_i) |=> !lat_q);

  assert_sleep_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |=> !lat_q);

endmodule

// File: rtl/ota_alarm.sv
module ota_alarm
  import ota_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [TEMP_W-1:0] smp_temp,
  input  logic [TEMP_W-1:0] trip_lvl,
  input  logic [TEMP_W-1:0] hyst_lvl,
  input  logic              cfg_sleep,
  input  logic              cfg_latched,
  input  logic              cfg_act_high,
  input  logic [1:0]        cfg_depth,
  input  logic              rd_pulse,
  output logic              alarm_out
);

  logic above_trip, below_hyst;
  logic match, hold, fire, alarm_raw;
  logic mode_q, mode_chg, cnt_clr, smp_en;

  ota_thresh_cmp #(.W(TEMP_W)) cmp_i (
    .temp_i       (smp_temp),
    .trip_i       (trip_lvl),
    .hyst_i       (hyst_lvl),
    .above_trip_o (above_trip),
    .below_hyst_o (below_hyst)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= cfg_latched;
  end

  always_comb begin
    mode_chg = cfg_latched != mode_q;
    cnt_clr  = cfg_sleep || mode_chg || hold;
    smp_en   = smp_valid && !cfg_sleep;
  end

  ota_fault_queue fq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_en_i (smp_en),
    .match_i  (match),
    .clr_i    (cnt_clr),
    .depth_i  (cfg_depth),
    .fire_o   (fire)
  );

  ota_event_state ev_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .latched_mode_i (cfg_latched),
    .sleep_i        (cfg_sleep),
    .rd_i           (rd_pulse),
    .above_trip_i   (above_trip),
    .below_hyst_i   (below_hyst),
    .fire_i         (fire),
    .match_o        (match),
    .hold_o         (hold),
    .alarm_o        (alarm_raw)
  );

  always_comb alarm_out = cfg_act_high ? alarm_raw : !alarm_raw;

  assert_no_fire_asleep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_sleep |-> !fire);

  assert_idle_no_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_valid && !rd_pulse && !cfg_sleep) |=> $stable(alarm_raw));

endmodule

// File: tb/ota_alarm_tb_top.sv
module ota_alarm_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       smp_valid, cfg_sleep, cfg_latched, cfg_act_high, rd_pulse;
  logic [8:0] smp_temp, trip_lvl, hyst_lvl;
  logic [1:0] cfg_depth;
  logic       alarm_out;

  int   n_run = 0, n_fail = 0;
  bit   done  = 0;
  bit   exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  ota_alarm dut_i (.*);

  // monitor: compare after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_run++;
        if (alarm_out !== e) begin
          n_fail++;
          $display("FAIL %s: alarm_out=%b expected %b", t, alarm_out, e);
        end
      end
    end
  end

  function automatic bit lvl(input bit active);
    return cfg_act_high ? active : !active;
  endfunction

  task automatic cfg(input bit sl, input bit lat, input bit hi, input logic [1:0] dep,
                     input logic [8:0] tr, input logic [8:0] hy, input bit act, input string t);
    @(negedge clk);
    cfg_sleep = sl; cfg_latched = lat; cfg_act_high = hi; cfg_depth = dep;
    trip_lvl = tr; hyst_lvl = hy; smp_valid = 0; rd_pulse = 0;
    exp_q.push_back(lvl(act)); tag_q.push_back(t);
  endtask

  task automatic drive(input logic [8:0] tmp, input bit v, input bit rd,
                       input bit act, input string t);
    @(negedge clk);
    smp_temp = tmp; smp_valid = v; rd_pulse = rd;
    exp_q.push_back(lvl(act)); tag_q.push_back(t);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; smp_valid = 0; smp_temp = 0; rd_pulse = 0;
    cfg_sleep = 0; cfg_latched = 0; cfg_act_high = 0; cfg_depth = 0;
    trip_lvl = 9'h0A0; hyst_lvl = 9'h096;
    repeat (3) @(negedge clk);
    rst_n = 1;
    cfg(0, 0, 0, 2'b00, 9'h0A0, 9'h096, 0, "R9 reset inactive high level");
    // comparator mode, depth 1
    drive(9'd100, 1, 0, 0, "R3 below trip");
    drive(9'd160, 1, 0, 0, "R3 equal trip no crossing");
    drive(9'd161, 1, 0, 1, "R11 R3 above trip asserts next edge");
    drive(9'd155, 1, 0, 1, "R3 between thresholds holds");
    drive(9'd150, 1, 0, 1, "R3 equal hyst holds");
    drive(9'd149, 1, 0, 0, "R3 below hyst releases");
    drive(9'd200, 0, 0, 0, "R2 invalid sample ignored");
    // depth 2
    cfg(0, 0, 0, 2'b01, 9'h0A0, 9'h096, 0, "R1 depth code 01");
    drive(9'd200, 1, 0, 0, "R1 first of two");
    drive(9'd100, 1, 0, 0, "R2 good sample clears count");
    drive(9'd200, 1, 0, 0, "R2 count restarted");
    drive(9'd200, 1, 0, 1, "R1 second consecutive trips");
    drive(9'd100, 1, 0, 1, "R1 first cold of two");
    drive(9'd100, 1, 0, 0, "R1 depth two release");
    // depth 4
    cfg(0, 0, 0, 2'b10, 9'h0A0, 9'h096, 0, "R1 depth code 10");
    for (int i = 0; i < 3; i++) drive(9'd200, 1, 0, 0, "R1 under four");
    drive(9'd200, 1, 0, 1, "R1 fourth trips");
    // depth 6
    cfg(0, 0, 0, 2'b11, 9'h0A0, 9'h096, 1, "R1 depth code 11");
    for (int i = 0; i < 5; i++) drive(9'd100, 1, 0, 1, "R1 under six");
    drive(9'd100, 1, 0, 0, "R1 sixth releases");
    // polarity
    cfg(0, 0, 1, 2'b00, 9'h0A0, 9'h096, 0, "R7 active high idle low");
    drive(9'd200, 1, 0, 1, "R7 active high asserted");
    drive(9'd0, 0, 1, 1, "R5 read ignored in comparator mode");
    cfg(1, 0, 1, 2'b00, 9'h0A0, 9'h096, 1, "R6 sleep keeps comparator alarm");
    drive(9'd100, 1, 0, 1, "R6 sample ignored asleep");
    cfg(0, 0, 1, 2'b00, 9'h0A0, 9'h096, 1, "R6 wake");
    drive(9'd100, 1, 0, 0, "R3 release after wake");
    // signed thresholds -10 / -20
    cfg(0, 0, 0, 2'b00, 9'h1F6, 9'h1EC, 0, "R10 negative thresholds");
    drive(9'h1F5, 1, 0, 0, "R10 -11 not above -10");
    drive(9'h000, 1, 0, 1, "R10 zero above -10");
    drive(9'h0FF, 1, 0, 1, "R10 +127.5 not below -20");
    drive(9'h1EB, 1, 0, 0, "R10 -21 below -20");
    // latched mode
    cfg(0, 1, 0, 2'b00, 9'h0A0, 9'h096, 0, "R9 latched mode idle");
    drive(9'd200, 1, 0, 1, "R4 hot event latches");
    drive(9'd100, 1, 0, 1, "R4 held while latched");
    drive(9'd0, 0, 1, 0, "R5 read clears");
    drive(9'd200, 1, 0, 0, "R4 hot ignored after clear");
    drive(9'd100, 1, 0, 1, "R4 cold event latches");
    drive(9'd200, 1, 0, 1, "R4 held");
    drive(9'd0, 0, 1, 0, "R5 read clears again");
    drive(9'd100, 1, 0, 0, "R4 cold ignored rearmed hot");
    drive(9'd200, 1, 0, 1, "R4 hot latches again");
    cfg(1, 1, 0, 2'b00, 9'h0A0, 9'h096, 0, "R6 sleep clears latch");
    cfg(0, 1, 0, 2'b00, 9'h0A0, 9'h096, 0, "R6 wake latched");
    drive(9'd100, 1, 0, 1, "R6 armed cold kept");
    drive(9'd0, 0, 1, 0, "R5 read clear");
    // mode change clears count
    cfg(0, 1, 0, 2'b01, 9'h0A0, 9'h096, 0, "R8 depth two latched");
    drive(9'd200, 1, 0, 0, "R8 one hot counted");
    cfg(0, 0, 0, 2'b01, 9'h0A0, 9'h096, 0, "R8 switch to comparator");
    drive(9'd200, 1, 0, 0, "R8 count restarted after mode change");
    drive(9'd200, 1, 0, 1, "R8 second trips");
    @(negedge clk);
    smp_valid = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule